// File: doc/BRIEF.md
# Write-Leveling Sequencer

This block runs the controller side of strobe-to-clock alignment for one byte lane. On a start request it sends the mode-register write that places the memory in leveling mode. It then enables and parks the strobe, waits out the first-edge delay and sends short strobe bursts. After each burst it samples the clock-level feedback that the memory returns asynchronously. Between samples it moves a delay-tap setting one step at a time, until the sampled feedback changes from 0 to 1.

The search direction is set by the first sample. If the first sample is 1, the tap walks down. If it is 0, the tap walks up. The result is the tap at which the feedback turns from 0 to 1. If the tap reaches either end of its range without finding that change, the block flags failure. In both cases it sends the mode-register write that leaves leveling mode, waits the command spacing and then pulses done. Only deselect cycles go out between the two mode-register writes. The delay line itself lives outside the block and simply follows the `tap` output.

Top module: `wl_seq`

## Requirements
- R1: One cycle after `start` is sampled high while idle, `cmd_mrw` is high for one cycle with `cmd_addr` = 2 and `cmd_op` = 8'h80 (bit 7 set). This is the entry write.
- R2: `dqs_oe` rises exactly PARK_DLY (20) cycles after the entry-write cycle. `dqs_pulse` is never high while `dqs_oe` is low.
- R3: The first `dqs_pulse` cycle comes exactly EDGE_DLY (40) cycles after the entry-write cycle.
- R4: Every strobe burst is exactly PULSES (at least 2) consecutive cycles of `dqs_pulse` high.
- R5: Feedback passes through a two-flop synchronizer. The decision on a sample (a tap change or the exit write) becomes visible exactly FB_WAIT+3 cycles after the last pulse cycle of the burst. The next burst starts the cycle after a tap change.
- R6: A first sample of 1 makes the tap step down, and a first sample of 0 makes it step up. The tap moves by exactly one per burst. The number of bursts is one plus the number of taps stepped.
- R7: On success, `tap` holds the lowest tap whose feedback is 1 when the tap below it gives 0, and `fail` is low at done.
- R8: If tap 0 still samples 1 while stepping down, or tap 2^TAP_W-1 still samples 0 while stepping up, `fail` is high at done and `tap` stays at that end.
- R9: The exit write is `cmd_mrw` with `cmd_addr` = 2 and `cmd_op` = 8'h00. `dqs_oe` is low from that cycle on. Between the entry and exit writes, `cmd_mrw` stays low.
- R10: `done` is a one-cycle pulse exactly MRW_GAP (10) cycles after the exit-write cycle. Any two mode-register writes are at least MRW_GAP cycles apart.
- R11: After reset, `cmd_mrw`, `dqs_oe`, `dqs_pulse`, `done` and `fail` are low and `tap` equals TAP_INIT.
- R12: `start` has no effect while a sequence is in progress; no extra mode-register write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a leveling sequence when idle |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No 0-to-1 transition found; valid at done |
| cmd_mrw | output | 1 | 1 = mode-register write, 0 = deselect |
| cmd_addr | output | 6 | Mode-register address for the write |
| cmd_op | output | 8 | Mode-register operand for the write |
| dqs_oe | output | 1 | Strobe driven (parked true-low, complement-high when not pulsing) |
| dqs_pulse | output | 1 | Request one strobe pulse this cycle |
| tap | output | TAP_W | Strobe delay-tap setting |
| fb_async | input | 1 | Asynchronous clock-level feedback from the memory |

## Verification
The bench places the feedback threshold at each edge of the tap range: tap 0 and one past the top, which must fail; tap 1 and the top tap, which reach an end and still succeed; and the taps next to the start point. A design with an off-by-one at a range end would report failure on a valid lane, or wrap the tap instead of failing. Cycle distances from the entry write to strobe enable and first pulse are measured exactly, and so are the distances from the last pulse to each decision and from the exit write to done. A design that sampled too early, skipped the synchronizer delay or shortened a burst to one pulse would therefore show up as a wrong distance. Stray start pulses during a run expose a sequencer that restarts mid-search, and the step-down case shows whether the final tap is moved back up by one.

// File: rtl/wl_seq_pkg.sv
package wl_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_BURST,
        ST_LISTEN,
        ST_GAP
    } wl_state_e;

    // Mode register and operand bit that switch leveling mode on and off
    localparam logic [5:0] MR_LEVEL_ADDR = 6'd2;
    localparam int         LEVEL_BIT     = 7;

    function automatic int wl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

    initial begin
        a_r5_sync_depth: assert (STAGES >= 2);
    end
endmodule

// File: rtl/wl_tap_edge.sv
module wl_tap_edge #(
    parameter int TAP_W = 5
) (
    input  logic [TAP_W-1:0] tap,
    output logic             at_min,
    output logic             at_max,
    output logic [TAP_W-1:0] tap_inc,
    output logic [TAP_W-1:0] tap_dec
);
    assign at_min  = (tap == '0);
    assign at_max  = (tap == '1);
    assign tap_inc = tap + TAP_W'(1);
    assign tap_dec = tap - TAP_W'(1);
endmodule

// File: rtl/wl_seq.sv
module wl_seq #(
    parameter int TAP_W       = 5,
    parameter int TAP_INIT    = 16,
    parameter int PARK_DLY    = 20,
    parameter int EDGE_DLY    = 40,
    parameter int FB_WAIT     = 5,
    parameter int MRW_GAP     = 10,
    parameter int PULSES      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             done,
    output logic             fail,
    output logic             cmd_mrw,
    output logic [5:0]       cmd_addr,
    output logic [7:0]       cmd_op,
    output logic             dqs_oe,
    output logic             dqs_pulse,
    output logic [TAP_W-1:0] tap,
    input  logic             fb_async
);
    import wl_seq_pkg::*;

    localparam int LISTEN_DLY = FB_WAIT + SYNC_STAGES;
    localparam int CNT_MAX    = wl_max(wl_max(EDGE_DLY, LISTEN_DLY), wl_max(MRW_GAP, PULSES));
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int GAP_W      = $clog2(EDGE_DLY + MRW_GAP + 1) + 1;

    typedef struct packed {
        wl_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [TAP_W-1:0]   tap;
        logic               first;
        logic               down;
        logic               fail;
        logic               done;
        logic               mrw;
        logic [7:0]         op;
        logic               oe;
        logic               pulse;
    } seq_t;

    seq_t q, d;

    logic             fb_s;
    logic             at_min, at_max;
    logic [TAP_W-1:0] tap_inc, tap_dec;

    wl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (fb_async),
        .q    (fb_s)
    );

    wl_tap_edge #(.TAP_W(TAP_W)) u_edge (
        .tap    (q.tap),
        .at_min (at_min),
        .at_max (at_max),
        .tap_inc(tap_inc),
        .tap_dec(tap_dec)
    );

    logic step_down, found, at_end;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.mrw     = 1'b0;
        d.op      = '0;
        d.pulse   = 1'b0;
        step_down = q.first ? fb_s : q.down;
        found     = !q.first && (q.down ? !fb_s : fb_s);
        at_end    = step_down ? at_min : at_max;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st            = ST_SETTLE;
                    d.cnt           = '0;
                    d.tap           = TAP_W'(TAP_INIT);
                    d.first         = 1'b1;
                    d.fail          = 1'b0;
                    d.mrw           = 1'b1;
                    d.op[LEVEL_BIT] = 1'b1;
                end
            end
            ST_SETTLE: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == CNT_W'(PARK_DLY - 1)) d.oe = 1'b1;
                if (q.cnt == CNT_W'(EDGE_DLY - 2)) begin
                    d.st  = ST_BURST;
                    d.cnt = '0;
                end
            end
            ST_BURST: begin
                if (q.cnt < CNT_W'(PULSES)) begin
                    d.pulse = 1'b1;
                    d.cnt   = q.cnt + CNT_W'(1);
                end else begin
                    d.st  = ST_LISTEN;
                    d.cnt = '0;
                end
            end
            ST_LISTEN: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == CNT_W'(LISTEN_DLY - 1)) begin
                    d.first = 1'b0;
                    d.down  = step_down;
                    if (found || at_end) begin
                        if (found && q.down) d.tap = tap_inc;
                        d.fail = !found;
                        d.mrw  = 1'b1;
                        d.oe   = 1'b0;
                        d.st   = ST_GAP;
                        d.cnt  = '0;
                    end else begin
                        d.tap = step_down ? tap_dec : tap_inc;
                        d.st  = ST_BURST;
                        d.cnt = '0;
                    end
                end
            end
            ST_GAP: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == CNT_W'(MRW_GAP - 1)) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.tap   <= TAP_W'(TAP_INIT);
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign fail      = q.fail;
    assign cmd_mrw   = q.mrw;
    assign cmd_addr  = q.mrw ? MR_LEVEL_ADDR : 6'd0;
    assign cmd_op    = q.op;
    assign dqs_oe    = q.oe;
    assign dqs_pulse = q.pulse;
    assign tap       = q.tap;

    // Cycles since the last mode-register write, saturating; for checks only
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        gap_q <= '1;
        else if (cmd_mrw)  gap_q <= '0;
        else if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
    end

    a_r1_entry_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start) |=> (cmd_mrw && cmd_addr == 6'd2 && cmd_op == 8'h80));
    a_r2_park_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dqs_oe) |-> (gap_q >= GAP_W'(PARK_DLY - 1)));
    a_r2_pulse_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse |-> dqs_oe);
    a_r3_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse |-> (gap_q >= GAP_W'(EDGE_DLY - 1)));
    a_r4_two_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dqs_pulse) |-> $past(dqs_pulse, 2));
    a_r8_fail_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (tap == '0 || tap == '1));
    a_r9_exit_drops_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mrw && !cmd_op[7]) |-> !dqs_oe);
    a_r10_mrw_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mrw |-> (gap_q >= GAP_W'(MRW_GAP - 1)));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    initial begin
        a_r4_pulse_param: assert (PULSES >= 2);
        a_r2_order_param: assert (PARK_DLY < EDGE_DLY - 1 && EDGE_DLY >= MRW_GAP);
    end
endmodule

// File: tb/wl_seq_test.sv
`timescale 1ns/1ps
module wl_seq_test;
    localparam int TAP_W    = 5;
    localparam int TAP_INIT = 16;
    localparam int PARK     = 20;
    localparam int EDGE     = 40;
    localparam int FBW      = 5;
    localparam int GAP      = 10;
    localparam int PULSES   = 2;
    localparam int TAP_MAX  = (1 << TAP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, fail, cmd_mrw, dqs_oe, dqs_pulse, fb_async;
    logic [5:0] cmd_addr;
    logic [7:0] cmd_op;
    logic [TAP_W-1:0] tap;

    int thr_g = 100;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign fb_async = (int'(tap) >= thr_g);

    wl_seq #(.TAP_W(TAP_W), .TAP_INIT(TAP_INIT), .PARK_DLY(PARK), .EDGE_DLY(EDGE),
             .FB_WAIT(FBW), .MRW_GAP(GAP), .PULSES(PULSES), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
        .cmd_mrw(cmd_mrw), .cmd_addr(cmd_addr), .cmd_op(cmd_op), .dqs_oe(dqs_oe),
        .dqs_pulse(dqs_pulse), .tap(tap), .fb_async(fb_async));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_tap(input int thr);
        if (thr <= 0) return 0;
        if (thr > TAP_MAX) return TAP_MAX;
        return thr;
    endfunction

    function automatic bit exp_fail(input int thr);
        return (thr <= 0) || (thr > TAP_MAX);
    endfunction

    function automatic int exp_bursts(input int thr);
        if (thr <= TAP_INIT) return (thr <= 0) ? TAP_INIT + 1 : TAP_INIT - thr + 2;
        return (thr > TAP_MAX) ? TAP_MAX - TAP_INIT + 1 : thr - TAP_INIT + 1;
    endfunction

    task automatic run(input int thr, input bit noisy);
        int cyc = 0, oe_at = -1, p1 = -1, last = -1, plen = 0, bursts = 0;
        int exit_at = -1, extra = 0, first_dir = 0;
        bit prev_p = 0, prev_oe = 0, fin = 0;
        logic [TAP_W-1:0] prev_tap;
        thr_g = thr;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(cmd_mrw && cmd_addr == 6'd2 && cmd_op == 8'h80, "R1 entry write", int'(cmd_op), 8'h80);
        prev_tap = tap;
        while (!fin && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start = noisy && (exit_at < 0) && ($urandom_range(0, 3) == 0);
            if (dqs_oe && !prev_oe) oe_at = cyc;
            if (dqs_pulse && !dqs_oe) check(0, "R2 pulse without oe", cyc, 0);
            if (dqs_pulse) begin
                if (p1 < 0) p1 = cyc;
                if (!prev_p) bursts++;
                plen++;
            end else if (prev_p) begin
                check(plen == PULSES, "R4 burst length", plen, PULSES);
                plen = 0;
                last = cyc - 1;
            end
            if (tap != prev_tap) begin
                check(last >= 0 && cyc - last == FBW + 3, "R5 step timing", cyc - last, FBW + 3);
                check(int'(tap) - int'(prev_tap) == 1 || int'(prev_tap) - int'(tap) == 1,
                      "R6 single step", int'(tap), int'(prev_tap));
                if (first_dir == 0) begin
                    first_dir = (tap > prev_tap) ? 1 : -1;
                    check(first_dir == ((TAP_INIT >= thr) ? -1 : 1), "R6 direction",
                          first_dir, (TAP_INIT >= thr) ? -1 : 1);
                end
            end
            if (cmd_mrw) begin
                if (cmd_op == 8'h00 && cmd_addr == 6'd2 && exit_at < 0) begin
                    exit_at = cyc;
                    check(cyc - last == FBW + 3, "R5 exit timing", cyc - last, FBW + 3);
                    check(!dqs_oe, "R9 oe low at exit", int'(dqs_oe), 0);
                end else extra++;
            end
            if (done) begin
                fin = 1;
                check(exit_at >= 0 && cyc - exit_at == GAP, "R10 done delay", cyc - exit_at, GAP);
                check(int'(tap) == exp_tap(thr), "R7 final tap", int'(tap), exp_tap(thr));
                check(fail == exp_fail(thr), "R8 fail flag", int'(fail), int'(exp_fail(thr)));
                check(bursts == exp_bursts(thr), "R6 burst count", bursts, exp_bursts(thr));
                check(oe_at == PARK, "R2 park delay", oe_at, PARK);
                check(p1 == EDGE, "R3 first edge", p1, EDGE);
                if (noisy) check(extra == 0, "R12 start ignored while busy", extra, 0);
                else       check(extra == 0, "R9 deselect only", extra, 0);
            end
            prev_p = dqs_pulse;
            prev_oe = dqs_oe;
            prev_tap = tap;
        end
        start = 1'b0;
        if (!fin) check(0, "R10 sequence never finished", cyc, 0);
        @(negedge clk);
        check(!done, "R10 done one cycle", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_mrw && !dqs_oe && !dqs_pulse && !done && !fail, "R11 reset outputs", 0, 0);
        check(int'(tap) == TAP_INIT, "R11 reset tap", int'(tap), TAP_INIT);
        run(TAP_INIT + 5, 1'b0);
        run(TAP_INIT - 4, 1'b0);
        run(0, 1'b0);
        run(TAP_MAX + 1, 1'b0);
        run(1, 1'b0);
        run(TAP_MAX, 1'b0);
        run(TAP_INIT, 1'b0);
        run(TAP_INIT + 1, 1'b1);
        for (int i = 0; i < 25; i++) begin
            int t;
            t = $urandom_range(0, TAP_MAX + 2);
            repeat ($urandom_range(0, 5)) @(negedge clk);
            run(t, $urandom_range(0, 1) == 1);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule